// File: doc/BRIEF.md
# Program Space Data Window Mapper

This block sits in a processor's data-read path and lets the upper half of the 16-bit data address range look into program memory. Each read request carries a data effective address, a byte/word flag, the window-enable bit from the core control register, an 8-bit window page and a hint that describes the instruction class. If the window is enabled and address bit 15 is set, the read is served from program memory. Otherwise it is served from data RAM.

A windowed read returns only the low 16 bits of a program word. The program byte address is formed from the page and the low 15 address bits. Bit 0 of the address picks the byte in byte mode. The block also computes how many extra cycles the access costs. That cost depends on the instruction class and on the state of a repeat loop, which is modelled only as two input flags. A four-state controller holds `busy_o` high for the lookup cycle plus the stall cycles and then pulses `rd_valid_o` for one cycle. Both memories are internal arrays that are loaded with a fixed arithmetic pattern at reset.

Controller states: IDLE waits for a request. LOOKUP decodes the request and registers the result. STALL counts down the extra cycles. RESP presents the result for one cycle. Transitions:
- IDLE→LOOKUP when a request is seen.
- LOOKUP→RESP when the stall count is zero.
- LOOKUP→STALL when the stall count is not zero.
- STALL→RESP on the last stall cycle.
- RESP→IDLE always.

Top module: `pgwin_mapper`

## Requirements
- R1: A read goes to program memory only when `win_en_i`=1 and `ea_i[15]`=1, and `from_prog_o` reports this. In every other case the read goes to data RAM. Data RAM ignores `ea_i[15]`, holds 2^DRAM_AW words indexed by `ea_i[DRAM_AW:1]`, and returns 0 when any of `ea_i[14:DRAM_AW+1]` is 1.
- R2: `pm_addr_o` equals {`page_i`, `ea_i[14:0]`}, which is 23 bits; address bit 15 takes no part in it.
- R3: A windowed word read returns the low 16 bits of the program word at index j = {`page_i[PG_BITS-1:0]`, `ea_i[OFF_BITS:1]`}.
  - Program word j holds 16'h8000 + j*16'h0205, taken modulo 2^16.
  - Data RAM word i holds 16'h4000 + i*16'h0123.
- R4: In byte mode (`byte_i`=1), `ea_i[0]`=0 returns bits 7:0 and `ea_i[0]`=1 returns bits 15:8, zero-extended to 16 bits. In word mode `ea_i[0]` is ignored.
- R5: A windowed read returns 0 in either of these cases:
  - `page_i[7]`=1, which selects configuration space.
  - The page or offset lies outside the implemented program area, that is, any of `page_i[6:PG_BITS]` or `ea_i[14:OFF_BITS+1]` is 1.
- R6: Outside a repeat loop, `stall_o` is set as follows:
  - 2 for a windowed read with class code 0 (other) or 3 (reserved).
  - 1 for a windowed read with class code 1 (move) or 2 (multiply-accumulate with prefetch).
  - 0 for any data-RAM read.
- R7: With `loop_on_i`=1, a windowed read stalls 0 cycles if `loop_edge_i`=0. If `loop_edge_i`=1 it stalls 2 cycles, whatever the class. The edge flag marks the first or last iteration, an interrupt exit or a re-entry. `loop_edge_i` has no effect when `loop_on_i`=0.
- R8: After the edge that captures a request, `busy_o` is high for exactly 1+`stall_o` cycles. `rd_valid_o` is then high for exactly one cycle, and it is never high while `busy_o` is high. The results stay unchanged until the next accepted request.
- R9: A request raised while `busy_o` or `rd_valid_o` is high is ignored; it leaves the current result unchanged and produces no extra `rd_valid_o`.
- R10: After reset, `busy_o`, `rd_valid_o`, `rd_data_o`, `pm_addr_o`, `from_prog_o` and `stall_o` are all 0, and both arrays hold their R3 patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 1 | Read request, taken in IDLE |
| ea_i | input | 16 | Data effective address |
| byte_i | input | 1 | 1 = byte read, 0 = word read |
| win_en_i | input | 1 | Window enable from core control |
| page_i | input | 8 | Window page |
| cls_i | input | 2 | Instruction class: 0 other, 1 move, 2 MAC with prefetch, 3 reserved |
| loop_on_i | input | 1 | Access is inside a repeat loop |
| loop_edge_i | input | 1 | Loop edge iteration or interrupt exit/re-entry |
| busy_o | output | 1 | Lookup or stall in progress |
| rd_valid_o | output | 1 | One-cycle result strobe |
| rd_data_o | output | 16 | Read data |
| pm_addr_o | output | 23 | Program byte address of the request |
| from_prog_o | output | 1 | Result came through the window |
| stall_o | output | 2 | Extra cycles charged |

## Verification
The bench uses the default parameters:
- DRAM_AW=5, a 32-word data RAM.
- PG_BITS=2 and OFF_BITS=5, four implemented pages of 32 words each.

With these sizes the last implemented program word (index 127) can be reached, and so can a word on a page other than zero. The same sizes make it possible to step just past the implemented offset or page and see a zero read. Because the arrays are small, data-RAM aliasing of the upper half when the window is off can be seen directly.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_STALL  = 2'd2,
        ST_RESP   = 2'd3
    } pgw_state_e;

    typedef enum logic [1:0] {
        CLS_OTHER = 2'd0,
        CLS_MOVE  = 2'd1,
        CLS_MACPF = 2'd2,
        CLS_RSVD  = 2'd3
    } pgw_cls_e;

    localparam int STALL_W    = 2;
    localparam int EA_W       = 16;
    localparam int PAGE_W     = 8;
    localparam int PM_ADDR_W  = PAGE_W + EA_W - 1;

endpackage

// File: rtl/pgwin_store.sv
module pgwin_store #(
    parameter int WIDTH = 16,
    parameter int AW    = 5,
    parameter int BASE  = 0,
    parameter int STEP  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WIDTH-1:0] mem [DEPTH];

    // Each entry is loaded with its arithmetic pattern at reset and then held.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        localparam logic [WIDTH-1:0] INIT_VAL = WIDTH'(BASE + g * STEP);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem[g] <= INIT_VAL;
            else        mem[g] <= mem[g];
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pgwin_decode.sv
module pgwin_decode
    import pgwin_pkg::*;
#(
    parameter int DRAM_AW  = 5,
    parameter int PG_BITS  = 2,
    parameter int OFF_BITS = 5
) (
    input  logic [EA_W-1:0]         ea,
    input  logic                    en,
    input  logic [PAGE_W-1:0]       page,
    output logic                    win_hit,
    output logic [PM_ADDR_W-1:0]    pm_addr,
    output logic [PG_BITS+OFF_BITS-1:0] pm_idx,
    output logic                    pm_ok,
    output logic [DRAM_AW-1:0]      dr_idx,
    output logic                    dr_ok
);
    logic cfg_sel;
    logic page_hi_clear;
    logic off_hi_clear;

    always_comb begin
        win_hit       = en & ea[EA_W-1];
        pm_addr       = {page, ea[EA_W-2:0]};
        cfg_sel       = page[PAGE_W-1];
        page_hi_clear = ((page[PAGE_W-2:0] >> PG_BITS) == '0);
        off_hi_clear  = ((ea[EA_W-2:0] >> (OFF_BITS + 1)) == '0);
        pm_idx        = {page[PG_BITS-1:0], ea[OFF_BITS:1]};
        pm_ok         = win_hit & ~cfg_sel & page_hi_clear & off_hi_clear;
        dr_idx        = ea[DRAM_AW:1];
        dr_ok         = ~win_hit & ((ea[EA_W-2:0] >> (DRAM_AW + 1)) == '0);
    end

endmodule

// File: rtl/pgwin_stall.sv
module pgwin_stall
    import pgwin_pkg::*;
(
    input  logic               win_hit,
    input  logic [1:0]         cls,
    input  logic               loop_on,
    input  logic               loop_edge,
    output logic [STALL_W-1:0] stall
);
    logic [STALL_W-1:0] by_class;

    always_comb begin
        unique case (pgw_cls_e'(cls))
            CLS_MOVE, CLS_MACPF: by_class = STALL_W'(1);
            CLS_OTHER, CLS_RSVD: by_class = STALL_W'(2);
        endcase

        if (!win_hit)      stall = '0;
        else if (loop_on)  stall = loop_edge ? STALL_W'(2) : '0;
        else               stall = by_class;
    end

endmodule

// File: rtl/pgwin_mapper.sv
module pgwin_mapper
    import pgwin_pkg::*;
#(
    parameter int DRAM_AW  = 5,
    parameter int PG_BITS  = 2,
    parameter int OFF_BITS = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_i,
    input  logic [15:0]           ea_i,
    input  logic                  byte_i,
    input  logic                  win_en_i,
    input  logic [7:0]            page_i,
    input  logic [1:0]            cls_i,
    input  logic                  loop_on_i,
    input  logic                  loop_edge_i,
    output logic                  busy_o,
    output logic                  rd_valid_o,
    output logic [15:0]           rd_data_o,
    output logic [22:0]           pm_addr_o,
    output logic                  from_prog_o,
    output logic [1:0]            stall_o
);
    localparam int PM_AW = PG_BITS + OFF_BITS;

    pgw_state_e state_q, state_d;

    // Captured request
    logic [EA_W-1:0]   cap_ea;
    logic              cap_byte;
    logic              cap_en;
    logic [PAGE_W-1:0] cap_page;
    logic [1:0]        cap_cls;
    logic              cap_loop_on;
    logic              cap_loop_edge;

    // Decode / stall results
    logic                 win_hit;
    logic [PM_ADDR_W-1:0] pm_addr;
    logic [PM_AW-1:0]     pm_idx;
    logic                 pm_ok;
    logic [DRAM_AW-1:0]   dr_idx;
    logic                 dr_ok;
    logic [STALL_W-1:0]   stall_calc;
    logic [15:0]          pm_word;
    logic [15:0]          dr_word;
    logic [15:0]          word_sel;
    logic [15:0]          data_fmt;

    // Result registers
    logic [STALL_W-1:0]   cnt_q;
    logic [15:0]          data_q;
    logic [PM_ADDR_W-1:0] addr_q;
    logic                 prog_q;
    logic [STALL_W-1:0]   stall_q;

    logic accept;

    pgwin_decode #(
        .DRAM_AW (DRAM_AW),
        .PG_BITS (PG_BITS),
        .OFF_BITS(OFF_BITS)
    ) u_decode (
        .ea      (cap_ea),
        .en      (cap_en),
        .page    (cap_page),
        .win_hit (win_hit),
        .pm_addr (pm_addr),
        .pm_idx  (pm_idx),
        .pm_ok   (pm_ok),
        .dr_idx  (dr_idx),
        .dr_ok   (dr_ok)
    );

    pgwin_stall u_stall (
        .win_hit   (win_hit),
        .cls       (cap_cls),
        .loop_on   (cap_loop_on),
        .loop_edge (cap_loop_edge),
        .stall     (stall_calc)
    );

    pgwin_store #(
        .WIDTH (16),
        .AW    (PM_AW),
        .BASE  (32'h8000),
        .STEP  (32'h0205)
    ) u_prog_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (pm_idx),
        .rdata (pm_word)
    );

    pgwin_store #(
        .WIDTH (16),
        .AW    (DRAM_AW),
        .BASE  (32'h4000),
        .STEP  (32'h0123)
    ) u_data_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (dr_idx),
        .rdata (dr_word)
    );

    assign accept = (state_q == ST_IDLE) && req_i;

    // Word source and byte formatting
    always_comb begin
        if (win_hit) word_sel = pm_ok ? pm_word : 16'h0000;
        else         word_sel = dr_ok ? dr_word : 16'h0000;

        if (cap_byte) data_fmt = {8'h00, cap_ea[0] ? word_sel[15:8] : word_sel[7:0]};
        else          data_fmt = word_sel;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_i) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = (stall_calc == '0) ? ST_RESP : ST_STALL;
            ST_STALL:  if (cnt_q == STALL_W'(1)) state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
        endcase
    end

    // Handshake outputs
    always_comb begin
        busy_o     = 1'b0;
        rd_valid_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_LOOKUP: busy_o = 1'b1;
            ST_STALL:  busy_o = 1'b1;
            ST_RESP:   rd_valid_o = 1'b1;
        endcase
    end

    // Request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_ea        <= '0;
            cap_byte      <= 1'b0;
            cap_en        <= 1'b0;
            cap_page      <= '0;
            cap_cls       <= '0;
            cap_loop_on   <= 1'b0;
            cap_loop_edge <= 1'b0;
        end else if (accept) begin
            cap_ea        <= ea_i;
            cap_byte      <= byte_i;
            cap_en        <= win_en_i;
            cap_page      <= page_i;
            cap_cls       <= cls_i;
            cap_loop_on   <= loop_on_i;
            cap_loop_edge <= loop_edge_i;
        end
    end

    // Result registers and stall counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            data_q  <= '0;
            addr_q  <= '0;
            prog_q  <= 1'b0;
            stall_q <= '0;
        end else if (state_q == ST_LOOKUP) begin
            cnt_q   <= stall_calc;
            data_q  <= data_fmt;
            addr_q  <= pm_addr;
            prog_q  <= win_hit;
            stall_q <= stall_calc;
        end else if (state_q == ST_STALL) begin
            cnt_q   <= cnt_q - STALL_W'(1);
        end
    end

    assign rd_data_o   = data_q;
    assign pm_addr_o   = addr_q;
    assign from_prog_o = prog_q;
    assign stall_o     = stall_q;

endmodule

// File: rtl/pgwin_mapper_chk.sv
module pgwin_mapper_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_i,
    input logic        byte_i,
    input logic        loop_on_i,
    input logic        loop_edge_i,
    input logic        busy_o,
    input logic        rd_valid_o,
    input logic [15:0] rd_data_o,
    input logic [22:0] pm_addr_o,
    input logic        from_prog_o,
    input logic [1:0]  stall_o
);
    logic       ck_byte_q;
    logic       ck_loop_on_q;
    logic       ck_loop_edge_q;
    logic [2:0] ck_busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_byte_q      <= 1'b0;
            ck_loop_on_q   <= 1'b0;
            ck_loop_edge_q <= 1'b0;
            ck_busy_cnt    <= '0;
        end else begin
            if (req_i && !busy_o && !rd_valid_o) begin
                ck_byte_q      <= byte_i;
                ck_loop_on_q   <= loop_on_i;
                ck_loop_edge_q <= loop_edge_i;
            end
            if (busy_o)          ck_busy_cnt <= ck_busy_cnt + 3'd1;
            else if (rd_valid_o) ck_busy_cnt <= '0;
        end
    end

    assert_valid_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && rd_valid_o));

    assert_valid_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o);

    assert_busy_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (ck_busy_cnt == {1'b0, stall_o} + 3'd1));

    assert_data_ram_no_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !from_prog_o) |-> (stall_o == 2'd0));

    assert_loop_steady_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && from_prog_o && ck_loop_on_q && !ck_loop_edge_q) |-> (stall_o == 2'd0));

    assert_config_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && from_prog_o && pm_addr_o[22]) |-> (rd_data_o == 16'h0000));

    assert_byte_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && ck_byte_q) |-> (rd_data_o[15:8] == 8'h00));

    assert_hold_after_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid_o && !busy_o && !$past(rd_valid_o)) |-> $stable(rd_data_o));

endmodule

bind pgwin_mapper pgwin_mapper_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .byte_i      (byte_i),
    .loop_on_i   (loop_on_i),
    .loop_edge_i (loop_edge_i),
    .busy_o      (busy_o),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .pm_addr_o   (pm_addr_o),
    .from_prog_o (from_prog_o),
    .stall_o     (stall_o)
);

// File: tb/pgwin_mapper_tb_top.sv
`timescale 1ns/1ps
module pgwin_mapper_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [15:0] ea_i = '0;
    logic        byte_i = 1'b0;
    logic        win_en_i = 1'b0;
    logic [7:0]  page_i = '0;
    logic [1:0]  cls_i = '0;
    logic        loop_on_i = 1'b0;
    logic        loop_edge_i = 1'b0;
    logic        busy_o;
    logic        rd_valid_o;
    logic [15:0] rd_data_o;
    logic [22:0] pm_addr_o;
    logic        from_prog_o;
    logic [1:0]  stall_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    pgwin_mapper dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .ea_i        (ea_i),
        .byte_i      (byte_i),
        .win_en_i    (win_en_i),
        .page_i      (page_i),
        .cls_i       (cls_i),
        .loop_on_i   (loop_on_i),
        .loop_edge_i (loop_edge_i),
        .busy_o      (busy_o),
        .rd_valid_o  (rd_valid_o),
        .rd_data_o   (rd_data_o),
        .pm_addr_o   (pm_addr_o),
        .from_prog_o (from_prog_o),
        .stall_o     (stall_o)
    );

    // {ea16, byte, en, page8, cls2, loop_on, loop_edge, exp_data16, exp_prog, exp_stall2}
    localparam int NV = 17;
    localparam logic [48:0] VEC [NV] = '{
        {16'h0004,1'b0,1'b1,8'h01,2'd0,1'b0,1'b0,16'h4246,1'b0,2'd0}, // R1 R3 RAM word 2
        {16'h0005,1'b1,1'b1,8'h01,2'd0,1'b0,1'b0,16'h0042,1'b0,2'd0}, // R4 high byte
        {16'h0004,1'b1,1'b1,8'h01,2'd0,1'b0,1'b0,16'h0046,1'b0,2'd0}, // R4 low byte
        {16'h8006,1'b0,1'b1,8'h01,2'd0,1'b0,1'b0,16'hC6AF,1'b1,2'd2}, // R3 R6 page 1 idx 35
        {16'h8006,1'b0,1'b0,8'h01,2'd0,1'b0,1'b0,16'h4369,1'b0,2'd0}, // R1 window off aliases RAM
        {16'h8007,1'b1,1'b1,8'h01,2'd1,1'b0,1'b0,16'h00C6,1'b1,2'd1}, // R4 R6 move class
        {16'h8006,1'b1,1'b1,8'h01,2'd2,1'b0,1'b0,16'h00AF,1'b1,2'd1}, // R4 R6 MAC prefetch
        {16'hFFFE,1'b0,1'b1,8'h01,2'd0,1'b0,1'b0,16'h0000,1'b1,2'd2}, // R5 offset beyond area
        {16'h8000,1'b0,1'b1,8'h80,2'd0,1'b0,1'b0,16'h0000,1'b1,2'd2}, // R5 configuration page
        {16'h8000,1'b0,1'b1,8'h04,2'd0,1'b0,1'b0,16'h0000,1'b1,2'd2}, // R5 page beyond area
        {16'h803E,1'b0,1'b1,8'h03,2'd0,1'b1,1'b0,16'h807B,1'b1,2'd0}, // R3 R7 last word, steady loop
        {16'h8002,1'b0,1'b1,8'h02,2'd1,1'b1,1'b1,16'h0345,1'b1,2'd2}, // R7 loop edge
        {16'h8002,1'b0,1'b0,8'h00,2'd0,1'b1,1'b0,16'h4123,1'b0,2'd0}, // R1 R7 off, loop
        {16'h7FFE,1'b0,1'b1,8'h01,2'd0,1'b0,1'b0,16'h0000,1'b0,2'd0}, // R1 below window
        {16'h003E,1'b0,1'b1,8'h00,2'd0,1'b0,1'b0,16'h633D,1'b0,2'd0}, // R3 last RAM word
        {16'h8000,1'b1,1'b1,8'h00,2'd1,1'b0,1'b1,16'h0000,1'b1,2'd1}, // R7 edge ignored outside loop
        {16'h8003,1'b0,1'b1,8'h00,2'd3,1'b0,1'b0,16'h8205,1'b1,2'd2}  // R4 R6 word ignores bit 0
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Issue one request; count busy cycles until the strobe.
    task automatic issue(input logic [15:0] ea, input logic bm, input logic en,
                         input logic [7:0] pg, input logic [1:0] cl,
                         input logic lo, input logic le,
                         output int busy_n, output logic got);
        @(negedge clk);
        ea_i = ea; byte_i = bm; win_en_i = en; page_i = pg; cls_i = cl;
        loop_on_i = lo; loop_edge_i = le; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        busy_n = 0;
        got = 1'b0;
        for (int k = 0; k < 16 && !got; k++) begin
            if (rd_valid_o) got = 1'b1;
            else begin
                if (busy_o) busy_n++;
                @(negedge clk);
            end
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            finish_run();
        end
    end

    initial begin
        int bn;
        logic got;
        logic [15:0] hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check("R10 busy", {31'd0, busy_o}, 32'd0);
        check("R10 valid", {31'd0, rd_valid_o}, 32'd0);
        check("R10 data", {16'd0, rd_data_o}, 32'd0);
        check("R10 addr_src_stall", {7'd0, pm_addr_o, from_prog_o, stall_o}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            logic [48:0] e;
            e = VEC[v];
            issue(e[48:33], e[32], e[31], e[30:23], e[22:21], e[20], e[19], bn, got);
            check("R8 strobe seen", {31'd0, got}, 32'd1);
            check("R1_R3_R4_R5 data", {16'd0, rd_data_o}, {16'd0, e[18:3]});
            check("R1 source", {31'd0, from_prog_o}, {31'd0, e[2]});
            check("R6_R7 stall", {30'd0, stall_o}, {30'd0, e[1:0]});
            check("R2 pm_addr", {9'd0, pm_addr_o}, {9'd0, e[30:23], e[47:33]});
            check("R8 busy cycles", bn, 32'd1 + e[1:0]);
            @(negedge clk);
            check("R8 one-cycle strobe", {31'd0, rd_valid_o}, 32'd0);
            check("R8 data held", {16'd0, rd_data_o}, {16'd0, e[18:3]});
        end

        // R9: request held high while busy must be ignored
        @(negedge clk);
        ea_i = 16'h8006; byte_i = 1'b0; win_en_i = 1'b1; page_i = 8'h01;
        cls_i = 2'd0; loop_on_i = 1'b0; loop_edge_i = 1'b0; req_i = 1'b1;
        @(negedge clk);
        ea_i = 16'h0004; win_en_i = 1'b0;   // different request kept asserted
        got = 1'b0;
        for (int k = 0; k < 16 && !got; k++) begin
            if (rd_valid_o) got = 1'b1;
            else @(negedge clk);
        end
        req_i = 1'b0;
        check("R9 first result kept", {16'd0, rd_data_o}, 32'h0000C6AF);
        hold = rd_data_o;
        bn = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (rd_valid_o) bn++;
        end
        check("R9 no extra strobe", bn, 32'd0);
        check("R9 data unchanged", {16'd0, rd_data_o}, {16'd0, hold});

        finish_run();
    end

endmodule